// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of saturating counters and a shift register that holds the outcomes of the most recent resolved branches. A lookup XORs the branch address bits with that outcome history to select one counter. The predicted direction is the counter's most significant bit. Because the history takes part in the index, one branch can use different counters depending on how the branches around it behaved. Several different branches can also end up sharing one counter.

The predict port has no clock stage. The caller presents the word-address bits of the branch PC and gets a direction back in the same cycle. It also gets the history value that was used to form the index. The caller keeps that history snapshot with the branch. When the branch resolves, the caller returns the PC bits, the snapshot and the real outcome on the update port. The update trains the counter the prediction came from, and the outcome is shifted into the history. The table size and the counter width are parameters. The defaults are 1024 entries of 3-bit counters. Setting IDX_W to 12 gives 4096 entries, which is 12 Kb of counter storage.

Top module: `gshare_pred`

## Requirements
- R1: After reset, the history register (`pred_hist_o`) is zero. Every counter holds the weakly-not-taken value 2^(CTR_W-1)-1 (3 for 3-bit counters), so every lookup predicts not-taken.
- R2: The prediction index is `pred_pc_i XOR pred_hist_o`, computed bitwise across IDX_W bits. The same PC bits can therefore select different counters under different histories.
- R3: A valid update with `upd_taken_i`=1 adds one to the selected counter. A counter already at 2^CTR_W-1 stays there.
- R4: A valid update with `upd_taken_i`=0 subtracts one from the selected counter. A counter at 0 stays at 0.
- R5: `pred_taken_o` is 1 exactly when the selected counter's most significant bit is 1. For 3-bit counters that means a value of 4 or more.
- R6: Each valid update shifts the history left by one bit. The outcome enters at bit 0 and the oldest bit (bit IDX_W-1) is dropped.
- R7: An update selects its counter with `upd_pc_i XOR upd_hist_i`. The current history register plays no part in choosing the update index.
- R8: While `upd_valid_i` is 0, the counters and the history do not change, whatever values are on the other update inputs.
- R9: The prediction follows the inputs in the same cycle. An update becomes visible from the cycle after its clock edge. A lookup of the entry that is being updated in the same cycle returns the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | IDX_W | Branch PC word-address bits used for the lookup |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_hist_o | output | IDX_W | Current global history; the caller keeps this as the update snapshot |
| upd_valid_i | input | 1 | Update strobe for one resolved branch |
| upd_pc_i | input | IDX_W | PC bits of the resolved branch |
| upd_hist_i | input | IDX_W | History snapshot taken when the branch was predicted |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench drives a single counter up to its ceiling and down to its floor, and checks the direction at each value. A design with a counter that wraps would flip the prediction at the extremes. A design with the wrong threshold would flip at the wrong count.

Updates are sent with a snapshot that differs from the live history. A design that indexes updates with the live history would then train the wrong entry. The bench also shifts in more outcomes than the history is wide, which exposes a design that does not drop the oldest bit.

Cycles with the update strobe low but the other update inputs active must leave the history and the target entry unchanged. A same-cycle lookup of the entry being written must return the old value. A design that forwards the new value, or ignores the strobe, fails these checks.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [IDX_W-1:0] hist_o
);
  logic [IDX_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[IDX_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] pc_i,
  input  logic [IDX_W-1:0] hist_i,
  output logic [IDX_W-1:0] idx_o
);
  assign idx_o = pc_i ^ hist_i;
endmodule

// File: rtl/gshare_ctr_next.sv
module gshare_ctr_next #(
  parameter int CTR_W = 3
) (
  input  logic [CTR_W-1:0] ctr_i,
  input  gshare_pkg::dir_e dir_i,
  output logic [CTR_W-1:0] ctr_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

  always_comb begin
    if (dir_i == gshare_pkg::DIR_TAKEN)
      ctr_o = (ctr_i == CTR_MAX) ? CTR_MAX : ctr_i + CTR_ONE;
    else
      ctr_o = (ctr_i == '0) ? '0 : ctr_i - CTR_ONE;
  end
endmodule

// File: rtl/gshare_ctr_table.sv
module gshare_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic [CTR_W-1:0] upd_ctr_o,
  input  logic             wr_en_i,
  input  logic [CTR_W-1:0] wr_ctr_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctr_q[g] <= CTR_INIT;
      else if (wr_en_i && (upd_idx_i == IDX_W'(g)))
        ctr_q[g] <= wr_ctr_i;
    end
  end

  // Reads see the stored value; a same-cycle write lands at the edge.
  assign rd_ctr_o  = ctr_q[rd_idx_i];
  assign upd_ctr_o = ctr_q[upd_idx_i];
endmodule

// File: rtl/gshare_pred.sv
module gshare_pred #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] pred_pc_i,
  output logic             pred_taken_o,
  output logic [IDX_W-1:0] pred_hist_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_pc_i,
  input  logic [IDX_W-1:0] upd_hist_i,
  input  logic             upd_taken_i
);
  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [CTR_W-1:0] rd_ctr;
  logic [CTR_W-1:0] upd_ctr;
  logic [CTR_W-1:0] wr_ctr;
  gshare_pkg::dir_e upd_dir;

  assign upd_dir = upd_taken_i ? gshare_pkg::DIR_TAKEN : gshare_pkg::DIR_NOT_TAKEN;

  gshare_hist #(.IDX_W(IDX_W)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .bit_i  (upd_taken_i),
    .hist_o (hist)
  );

  gshare_index #(.IDX_W(IDX_W)) u_rd_index (
    .pc_i  (pred_pc_i),
    .hist_i(hist),
    .idx_o (rd_idx)
  );

  gshare_index #(.IDX_W(IDX_W)) u_upd_index (
    .pc_i  (upd_pc_i),
    .hist_i(upd_hist_i),
    .idx_o (upd_idx)
  );

  gshare_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_ctr_o (rd_ctr),
    .upd_idx_i(upd_idx),
    .upd_ctr_o(upd_ctr),
    .wr_en_i  (upd_valid_i),
    .wr_ctr_i (wr_ctr)
  );

  gshare_ctr_next #(.CTR_W(CTR_W)) u_next (
    .ctr_i(upd_ctr),
    .dir_i(upd_dir),
    .ctr_o(wr_ctr)
  );

  assign pred_taken_o = rd_ctr[CTR_W-1];
  assign pred_hist_o  = hist;
endmodule

// File: rtl/gshare_pred_chk.sv
module gshare_pred_chk #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic [IDX_W-1:0] hist_i,
  input logic [CTR_W-1:0] upd_ctr_i,
  input logic [CTR_W-1:0] wr_ctr_i
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

  // R3
  ctr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && (upd_ctr_i != CTR_MAX) |-> wr_ctr_i == upd_ctr_i + CTR_ONE);
  // R3
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_taken_i && (upd_ctr_i == CTR_MAX) |-> wr_ctr_i == CTR_MAX);
  // R4
  ctr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && (upd_ctr_i != '0) |-> wr_ctr_i == upd_ctr_i - CTR_ONE);
  // R4
  ctr_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !upd_taken_i && (upd_ctr_i == '0) |-> wr_ctr_i == '0);
  // R6
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_i == {$past(hist_i[IDX_W-2:0]), $past(upd_taken_i)});
  // R8
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_i));
endmodule

bind gshare_pred gshare_pred_chk #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_valid_i(upd_valid_i),
  .upd_taken_i(upd_taken_i),
  .hist_i     (pred_hist_o),
  .upd_ctr_i  (upd_ctr),
  .wr_ctr_i   (wr_ctr)
);

// File: tb/gshare_pred_bench.sv
module gshare_pred_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 10;
  localparam int CTR_W = 3;
  localparam int DEPTH = 1 << IDX_W;
  localparam int CTR_MAX = (1 << CTR_W) - 1;
  localparam int CTR_INIT = (1 << (CTR_W - 1)) - 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [IDX_W-1:0] pred_pc = '0;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_hist;
  logic             upd_valid = 1'b0;
  logic [IDX_W-1:0] upd_pc = '0;
  logic [IDX_W-1:0] upd_hist = '0;
  logic             upd_taken = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gshare_pred #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_gshare_pred (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pred_pc_i   (pred_pc),
    .pred_taken_o(pred_taken),
    .pred_hist_o (pred_hist),
    .upd_valid_i (upd_valid),
    .upd_pc_i    (upd_pc),
    .upd_hist_i  (upd_hist),
    .upd_taken_i (upd_taken)
  );

  typedef struct {
    logic             taken;
    logic [IDX_W-1:0] hist;
    string            req;
  } exp_t;

  exp_t             sb_q[$];
  int               n_checks = 0;
  int               n_errors = 0;
  bit               done = 0;
  int               m_ctr[DEPTH];
  logic [IDX_W-1:0] m_hist = '0;

  // Driver: one cycle per call; expectation from the model before the edge.
  task automatic step(input logic [IDX_W-1:0] ppc, input logic uv,
                      input logic [IDX_W-1:0] upc, input logic [IDX_W-1:0] uh,
                      input logic ut, input string req);
    exp_t e;
    int   ui;
    @(negedge clk);
    pred_pc   = ppc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_hist  = uh;
    upd_taken = ut;
    e.taken = (m_ctr[int'(ppc ^ m_hist)] >= (1 << (CTR_W - 1)));
    e.hist  = m_hist;
    e.req   = req;
    sb_q.push_back(e);
    if (uv) begin
      ui = int'(upc ^ uh);
      if (ut) m_ctr[ui] = (m_ctr[ui] == CTR_MAX) ? CTR_MAX : m_ctr[ui] + 1;
      else    m_ctr[ui] = (m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1;
      m_hist = {m_hist[IDX_W-2:0], ut};
    end
  endtask

  // Lookup-only cycle aimed at table entry idx under the current history.
  task automatic peek(input logic [IDX_W-1:0] idx, input string req);
    step(idx ^ m_hist, 1'b0, '0, '0, 1'b0, req);
  endtask

  // Monitor: compares just after each falling edge, away from the rising edge.
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (pred_taken !== e.taken || pred_hist !== e.hist) begin
        n_errors++;
        $display("FAIL %s: taken=%b hist=%h expected taken=%b hist=%h",
                 e.req, pred_taken, pred_hist, e.taken, e.hist);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  localparam logic [IDX_W-1:0] T_A = 10'h055;
  localparam logic [IDX_W-1:0] T_B = 10'h0F0;
  localparam logic [IDX_W-1:0] T_C = 10'h200;
  localparam logic [IDX_W-1:0] T_D = 10'h133;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = CTR_INIT;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state, several lookups
    step(10'h000, 0, '0, '0, 0, "R1");
    step(10'h3FF, 0, '0, '0, 0, "R1");
    step(10'h155, 0, '0, '0, 0, "R1");

    // R3 R5: climb one entry past its ceiling, snapshot fixed at zero
    for (int i = 0; i < 6; i++) step(T_A ^ m_hist, 1, T_A, '0, 1, "R3_R5");
    peek(T_A, "R3_sat");
    // R4 R5: descend past the floor
    for (int i = 0; i < 9; i++) step(T_A ^ m_hist, 1, T_A, '0, 0, "R4_R5");
    peek(T_A, "R4_sat");
    step(T_A ^ m_hist, 1, T_A, '0, 1, "R4");
    peek(T_A, "R4");

    // R6: more outcomes than history bits
    for (int i = 0; i < IDX_W + 3; i++)
      step(10'h011, 1, 10'h300, 10'(i), (i % 3) != 0, "R6");
    peek(10'h011, "R6");

    // R7: snapshot differs from live history
    step(T_B ^ m_hist, 1, T_B, 10'h00F, 1, "R7");
    step(T_B ^ m_hist, 1, T_B, 10'h00F, 1, "R7");
    peek(T_B, "R7_untouched");
    peek(T_B ^ 10'h00F, "R7_trained");

    // R8: strobe low, other update inputs active
    for (int i = 0; i < 3; i++) step(T_C ^ m_hist, 0, T_C, '0, 1, "R8");
    peek(T_C, "R8");

    // R9: same-cycle lookup of the entry being written returns old value
    step(T_D ^ m_hist, 1, T_D, m_hist, 1, "R9_old");
    step(T_D ^ 10'h0AA ^ m_hist, 1, T_D ^ 10'h0AA, m_hist, 1, "R9");
    peek(T_D, "R9_new");

    // R2: same PC bits, different histories select different counters
    step(10'h021 ^ m_hist, 1, 10'h021, m_hist, 1, "R2");
    step(10'h021, 0, '0, '0, 0, "R2");
    step(10'h021, 1, 10'h021, m_hist, 0, "R2");
    step(10'h021, 0, '0, '0, 0, "R2");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule